// File: doc/BRIEF.md
# Streaming Read Prefetch Buffer

This block sits between one accelerator's DMA read port and a shared SDRAM controller. Once the DMA hands it a starting byte address, it fetches the next eight words of the stream in a single SDRAM burst and keeps them in a small shift-register buffer. It raises a full flag when all eight words are present. A system-level start signal waits until every client's full flag is high.

While the accelerator runs, it reads the stream one word at a time. When a read strobe carries the address the buffer expects next and a word is buffered, the block acknowledges the read in the same cycle with the oldest word, and no SDRAM access takes place. When the buffer runs dry, the block raises an empty flag, which tells the arbiter to move this client to the lowest priority. It then refills with another eight-word burst that continues from where the previous burst ended. A read at any other address throws the buffered words away and restarts the stream at that address. That read is held until its word arrives.

Top module: `pf_stream_prefetch`

## Requirements
- R1: During and after reset, and until a base address has been accepted, `rd_ack`, `mem_req`, `buf_full` and `buf_empty` are all low.
- R2: A one-cycle `dma_base_vld` pulse starts a burst request whose `mem_addr` equals the base address. `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_gnt` is high.
- R3: Once eight words have been collected, `buf_full` is high. No SDRAM request is made while the buffer is full.
- R4: A strobe whose address equals the next expected address, while at least one word is buffered, is acknowledged in the same cycle. Its data is the oldest buffered word, and no SDRAM request is made for it. The expected address then advances by 4 bytes.
- R5: While the stream is active and no word is buffered, `buf_empty` is high. A refill burst is requested, and its address is the previous burst's address plus 32 bytes.
- R6: Each granted request is followed by exactly eight `mem_rvld` beats. The beats carry consecutive words starting at the request address, and they are served to the client in arrival order.
- R7: A strobe whose address differs from the next expected address discards the buffered words. After any burst already in flight has finished, a burst is requested at the strobe's address. The strobe is acknowledged only when that word has arrived, and the acknowledgement is never in the strobe's first cycle.
- R8: Strobes issued before any base address is accepted are never acknowledged and cause no SDRAM request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_base_vld | input | 1 | One-cycle pulse: start a new stream |
| dma_base_addr | input | 32 | Byte address of the first stream word |
| rd_stb | input | 1 | Client read strobe, held until acknowledged |
| rd_addr | input | 32 | Client read byte address |
| rd_ack | output | 1 | Read acknowledge (same cycle on a hit) |
| rd_data | output | 32 | Read data, valid with `rd_ack` |
| mem_req | output | 1 | Burst request to SDRAM controller |
| mem_addr | output | 32 | Burst start byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvld | input | 1 | Burst data beat valid |
| mem_rdata | input | 32 | Burst data beat |
| buf_full | output | 1 | All eight buffer entries hold data |
| buf_empty | output | 1 | Stream active and buffer holds no word |

## Verification
The embedded assertions check, on every cycle, that the buffer never overflows or underflows and that a pending request keeps its address until granted. They also check that a burst ends on its last beat, that no request is made while the buffer is full, that every acknowledge is backed by a stored word, and that an empty idle buffer always starts a refill. Only the bench scenarios can show the rest: that the data returned matches the memory contents at the requested address, that hits are acknowledged without waiting, that refill addresses continue the stream, and that a miss restarts fetching at the strobe's address.

// File: rtl/pfb_pkg.sv
// Shared types for the streaming prefetch buffer.
// Assumes: one burst in flight at a time per client.
package pfb_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_BEAT = 2'd2
    } fetch_st_t;
endpackage

// File: rtl/pfb_store.sv
// Shift-register word store: pops from entry 0 and appends at the fill level.
// Assumes: the caller never pushes into a full store without a pop in the
// same cycle, and never pops an empty store. A flush is never given in a
// cycle that pushes or pops.
module pfb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] ent_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wr_idx;

    // Slot written by a push, one lower when a pop shifts in the same cycle.
    assign wr_idx = pop ? cnt_q - CW'(1) : cnt_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Entry update: take the pushed word, else shift down on a pop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (push && wr_idx == CW'(i)) begin
                ent_q[i] <= push_data;
            end else if (pop) begin
                if (i == DEPTH - 1) begin
                    ent_q[i] <= '0;
                end else begin
                    ent_q[i] <= ent_q[(i + 1) % DEPTH];
                end
            end
        end
    end

    // Fill level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q <= '0;
        end else if (push && !pop) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop && !push) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign head  = ent_q[0];
    assign count = cnt_q;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt_q < CW'(DEPTH)));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/pfb_fetch.sv
// Burst fetch engine: issues one DEPTH-beat read burst per start request.
// A jump loads a new stream cursor; otherwise the cursor continues past the
// previous burst. Assumes the memory side returns exactly DEPTH beats per grant.
module pfb_fetch
    import pfb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DEPTH      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          jump,
    input  logic [AW-1:0] jump_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvld,
    output logic          busy,
    output logic          push
);
    localparam int BW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] STRIDE = AW'(DEPTH * WORD_BYTES);

    fetch_st_t     st_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] cursor_q;
    logic [BW-1:0] beat_q;
    logic [AW-1:0] start_addr;

    // Address of the burst about to be requested.
    assign start_addr = jump ? jump_addr : cursor_q;

    // Burst sequencing: request, wait for grant, count beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FS_IDLE;
            addr_q   <= '0;
            cursor_q <= '0;
            beat_q   <= '0;
        end else begin
            case (st_q)
                FS_IDLE: if (go) begin
                    addr_q   <= start_addr;
                    cursor_q <= start_addr + STRIDE;
                    st_q     <= FS_REQ;
                end
                FS_REQ: if (mem_gnt) begin
                    beat_q <= '0;
                    st_q   <= FS_BEAT;
                end
                FS_BEAT: if (mem_rvld) begin
                    beat_q <= beat_q + BW'(1);
                    if (beat_q == BW'(DEPTH - 1)) begin
                        st_q <= FS_IDLE;
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    assign mem_req  = (st_q == FS_REQ);
    assign mem_addr = addr_q;
    assign busy     = (st_q != FS_IDLE);
    assign push     = (st_q == FS_BEAT) && mem_rvld;

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    a_r6_burst_ends_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(push));
endmodule

// File: rtl/pfb_track.sv
// Stream tracker: holds the next expected address and decides hits and restarts.
// A base pulse that arrives while a burst is in flight is held pending.
// Assumes: the read strobe is held until it is acknowledged.
module pfb_track #(
    parameter int AW         = 32,
    parameter int CW         = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_vld,
    input  logic [AW-1:0] base_addr,
    input  logic          stb,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] count,
    input  logic          fetch_busy,
    output logic          hit,
    output logic          restart,
    output logic [AW-1:0] restart_addr,
    output logic          active
);
    logic          act_q;
    logic [AW-1:0] next_q;
    logic          pend_q;
    logic [AW-1:0] pend_addr_q;
    logic          new_stream;
    logic          miss;

    // Classify the current cycle: new stream, miss or hit.
    always_comb begin
        new_stream   = base_vld || pend_q;
        miss         = act_q && stb && (addr != next_q);
        restart      = !fetch_busy && (new_stream || miss);
        restart_addr = base_vld ? base_addr : (pend_q ? pend_addr_q : addr);
        hit          = act_q && !new_stream && stb && (count != '0) && (addr == next_q);
    end

    // Expected-address and pending-base state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q       <= 1'b0;
            next_q      <= '0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (restart) begin
            act_q  <= 1'b1;
            next_q <= restart_addr;
            pend_q <= 1'b0;
        end else begin
            if (base_vld) begin
                pend_q      <= 1'b1;
                pend_addr_q <= base_addr;
            end
            if (hit) begin
                next_q <= next_q + AW'(WORD_BYTES);
            end
        end
    end

    assign active = act_q;

    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (next_q == $past(next_q) + AW'(WORD_BYTES)));
    a_r7_restart_target: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (act_q && next_q == $past(restart_addr)));
endmodule

// File: rtl/pf_stream_prefetch.sv
// Top: per-client streaming prefetch buffer. Hits are acknowledged
// combinationally from the buffer head. An empty buffer triggers a refill
// burst, and a miss flushes and restarts the stream.
// Assumes: a single requester and one SDRAM burst in flight at a time.
module pf_stream_prefetch #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DEPTH      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_base_vld,
    input  logic [AW-1:0] dma_base_addr,
    input  logic          rd_stb,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ack,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvld,
    input  logic [DW-1:0] mem_rdata,
    output logic          buf_full,
    output logic          buf_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [DW-1:0] head;
    logic          hit;
    logic          restart;
    logic [AW-1:0] restart_addr;
    logic          active;
    logic          fetch_busy;
    logic          push;
    logic          go;

    pfb_track #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_vld     (dma_base_vld),
        .base_addr    (dma_base_addr),
        .stb          (rd_stb),
        .addr         (rd_addr),
        .count        (count),
        .fetch_busy   (fetch_busy),
        .hit          (hit),
        .restart      (restart),
        .restart_addr (restart_addr),
        .active       (active)
    );

    // Start a burst on a restart, or refill an idle, drained stream.
    assign go = restart || (active && count == '0 && !fetch_busy);

    pfb_fetch #(.AW(AW), .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .jump      (restart),
        .jump_addr (restart_addr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_gnt   (mem_gnt),
        .mem_rvld  (mem_rvld),
        .busy      (fetch_busy),
        .push      (push)
    );

    pfb_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (restart),
        .push      (push),
        .push_data (mem_rdata),
        .pop       (hit),
        .head      (head),
        .count     (count)
    );

    assign rd_ack    = hit;
    assign rd_data   = head;
    assign buf_full  = (count == CW'(DEPTH));
    assign buf_empty = active && (count == '0);

    a_r3_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !mem_req);
    a_r4_ack_backed: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (count != '0 && rd_stb));
    a_r5_empty_refills: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && !fetch_busy) |=> fetch_busy);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!rd_ack && !buf_empty));
endmodule

// File: tb/pf_stream_prefetch_bench.sv
module pf_stream_prefetch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_base_vld = 1'b0;
    logic [31:0] dma_base_addr = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_ack;
    logic [31:0] rd_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt;
    logic        mem_rvld = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        buf_full;
    logic        buf_empty;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pf_stream_prefetch u_pf_stream_prefetch (
        .clk(clk), .rst_n(rst_n),
        .dma_base_vld(dma_base_vld), .dma_base_addr(dma_base_addr),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvld(mem_rvld), .mem_rdata(mem_rdata),
        .buf_full(buf_full), .buf_empty(buf_empty)
    );

    // Memory contents model.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A3C_96E1;
    endfunction

    // SDRAM model: random grant, CAS latency 3, eight contiguous beats.
    logic        gnt_en = 1'b0;
    int          lat_left = 0;
    int          beats_left = 0;
    logic [31:0] cur_addr = '0;
    logic [31:0] last_gnt_addr = '0;
    int          grants = 0;

    assign mem_gnt = mem_req && gnt_en;

    always @(posedge clk) begin
        gnt_en <= ($urandom % 3) != 0;
        if (mem_req && mem_gnt) begin
            cur_addr      <= mem_addr;
            last_gnt_addr <= mem_addr;
            lat_left      <= 3;
            beats_left    <= 8;
            grants        <= grants + 1;
            mem_rvld      <= 1'b0;
        end else if (beats_left > 0) begin
            if (lat_left > 0) begin
                lat_left <= lat_left - 1;
                mem_rvld <= 1'b0;
            end else begin
                mem_rvld   <= 1'b1;
                mem_rdata  <= mem_word(cur_addr);
                cur_addr   <= cur_addr + 32'd4;
                beats_left <= beats_left - 1;
            end
        end else begin
            mem_rvld <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read: hold the strobe until acknowledged, check the returned word.
    task automatic do_read(input logic [31:0] a, input string req, output int waited);
        waited = 0;
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        #1;
        while (!rd_ack && waited < 400) begin
            @(negedge clk);
            #1;
            waited++;
        end
        chk(rd_ack == 1'b1, req, {31'd0, rd_ack}, 32'd1);
        chk(rd_data == mem_word(a), req, rd_data, mem_word(a));
        @(posedge clk);
        #1;
        rd_stb = 1'b0;
    endtask

    task automatic wait_req(input int limit);
        for (int i = 0; i < limit && !mem_req; i++) begin
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int w;
        int acks;
        int g0;
        logic [31:0] nxt;
        logic [31:0] ma;
        void'($urandom(32'd1234));

        // R1: reset state.
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({rd_ack, mem_req, buf_full, buf_empty} == 4'b0, "R1 reset outputs",
            {28'd0, rd_ack, mem_req, buf_full, buf_empty}, 32'd0);
        rst_n = 1'b1;

        // R8: strobes before any base are ignored.
        acks = 0;
        rd_stb = 1'b1;
        rd_addr = 32'h100;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            if (rd_ack || mem_req) acks++;
        end
        rd_stb = 1'b0;
        chk(acks == 0, "R8 no ack/req before base", acks, 0);
        chk({buf_full, buf_empty} == 2'b0, "R1 flags idle after reset", {30'd0, buf_full, buf_empty}, 0);

        // R2: base pulse starts a burst at the base address.
        @(negedge clk);
        dma_base_vld  = 1'b1;
        dma_base_addr = 32'h0000_1000;
        @(negedge clk);
        dma_base_vld = 1'b0;
        wait_req(20);
        chk(mem_req && mem_addr == 32'h1000, "R2 first burst address", mem_addr, 32'h1000);

        // R3: buffer fills and then stays quiet.
        for (int i = 0; i < 100 && !buf_full; i++) @(negedge clk);
        chk(buf_full == 1'b1, "R3 full after setup", {31'd0, buf_full}, 1);
        acks = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (mem_req || !buf_full) acks++;
        end
        chk(acks == 0, "R3 no request while full", acks, 0);

        // R4: eight hits acknowledged without waiting and without SDRAM access.
        g0 = grants;
        for (int i = 0; i < 8; i++) begin
            do_read(32'h1000 + 32'(i * 4), "R4 hit data", w);
            chk(w == 0, "R4 hit same-cycle ack", w, 0);
            if (i < 7) chk(grants == g0 && !mem_req, "R4 no SDRAM on hit", grants, g0);
        end

        // R5: empty flag and continuing refill address.
        @(negedge clk);
        chk(buf_empty == 1'b1, "R5 empty after drain", {31'd0, buf_empty}, 1);
        wait_req(20);
        chk(mem_addr == 32'h1020, "R5 refill continues", mem_addr, 32'h1020);

        // R6: long sequential stream with random gaps.
        nxt = 32'h1020;
        for (int i = 0; i < 60; i++) begin
            repeat ($urandom % 3) @(negedge clk);
            do_read(nxt, "R6 stream order", w);
            nxt = nxt + 32'd4;
        end

        // R7: random misses restart the stream at the strobe address.
        for (int k = 0; k < 6; k++) begin
            ma = nxt + 32'h400 + 32'(($urandom % 256) * 4);
            do_read(ma, "R7 miss data", w);
            chk(w > 0, "R7 miss is stalled", w, 1);
            chk(last_gnt_addr == ma, "R7 restart burst address", last_gnt_addr, ma);
            nxt = ma + 32'd4;
            for (int j = 0; j < 10; j++) begin
                repeat ($urandom % 2) @(negedge clk);
                do_read(nxt, "R6 stream after restart", w);
                nxt = nxt + 32'd4;
            end
        end

        // R2: a new base mid-stream restarts prefetch at that address.
        @(negedge clk);
        dma_base_vld  = 1'b1;
        dma_base_addr = 32'h0008_0000;
        @(negedge clk);
        dma_base_vld = 1'b0;
        for (int i = 0; i < 100 && !buf_full; i++) @(negedge clk);
        chk(buf_full && last_gnt_addr == 32'h8_0000, "R2 rebase burst", last_gnt_addr, 32'h8_0000);
        for (int i = 0; i < 12; i++) do_read(32'h8_0000 + 32'(i * 4), "R6 rebased stream", w);

        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule